// File: doc/BRIEF.md
# Bus Clock Divisor Selection Engine

This block works out legal divider settings for a clock tree: a high-speed bus divisor, a combined peripheral bus divisor, and whether the core clock should run in a lowered-voltage scaling mode. It takes a source frequency and a requested core frequency, plus upper limits for the high-speed bus and the peripheral bus. All frequencies are unsigned values in Hz. A one-cycle start strobe latches the inputs. The block then runs a sequential search over candidate divisors. Each quotient comes from an internal restoring divider that produces one bit per cycle.

When the search finishes, the block pulses a done flag for one cycle. It either updates its result outputs or raises an error flag. On an error the previous results stay in place. The block makes no clocks and programs no registers. A controller reads the results and applies them.

Top module: `bus_div_select`

## Requirements
- R1: A synchronous active-high reset sets hdiv, pdiv, scale_mode, core_adj, done and err all to zero.
- R2: A requested core frequency above the source frequency is clamped to the source frequency before any other step.
- R3: When the clamped core frequency is below the source frequency and also below the high-speed bus limit, the bus limit used in the search becomes the core frequency.
- R4: Candidate high-speed divisors are tried in ascending order 1, 2, 3, 4, 6, 8. The first candidate whose floor quotient (source / divisor) is at most the limit plus 1000 Hz is chosen and reported on hdiv as its plain binary value.
- R5: If no candidate is accepted, err is set, and hdiv, pdiv, scale_mode and core_adj keep their previous values.
- R6: Let B be the chosen bus frequency. The peripheral sub-divisor is 2 if B exceeds the peripheral limit, else 1. If the sub-divisor is 2 and floor(B/2) still exceeds the limit, err is set and all results are kept. Otherwise pdiv = sub-divisor × hdiv.
- R7: The core frequency is raised to B if it is below B. If the result is below the source frequency, scale_mode is 1 and core_adj equals B. Otherwise scale_mode is 0 and core_adj equals that core frequency.
- R8: done is low while a computation runs and is high for exactly one cycle when it ends. err is valid in that cycle and holds until the next accepted start. A successful computation clears err.
- R9: A start strobe during a computation is ignored. The result reflects only the inputs latched at the accepted start.
- R10: A start strobe in the same cycle as done is accepted and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (one-cycle strobe) |
| src_hz | input | 32 | Source frequency in Hz |
| core_hz | input | 32 | Requested core frequency in Hz |
| hbus_max_hz | input | 32 | Maximum high-speed bus frequency in Hz |
| pbus_max_hz | input | 32 | Maximum peripheral bus frequency in Hz |
| hdiv | output | 4 | Chosen high-speed bus divisor |
| pdiv | output | 5 | Combined peripheral divisor |
| scale_mode | output | 1 | Core runs from the bus clock (scaling mode) |
| core_adj | output | 32 | Adjusted core frequency in Hz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No legal setting found |

## Verification
Two events can fall in the same cycle: the done pulse that ends one computation, and the start strobe that begins the next. The driver raises start in the very cycle where it sees done high. The next result must then match the model for the new inputs, with err from the previous result replaced.

A second collision is a start that arrives while a computation is still running. The driver sends a strobe with different operands a few cycles into a computation, and queues no expectation for it. The monitor then judges that only the first operands produced a result and that no extra done pulse appeared.

// File: rtl/bus_div_select.sv
module bus_div_select #(
  parameter int FW  = 32,
  parameter int HW  = 4,
  parameter int TOL = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] src_hz,
  input  logic [FW-1:0] core_hz,
  input  logic [FW-1:0] hbus_max_hz,
  input  logic [FW-1:0] pbus_max_hz,
  output logic [HW-1:0] hdiv,
  output logic [HW:0]   pdiv,
  output logic          scale_mode,
  output logic [FW-1:0] core_adj,
  output logic          done,
  output logic          err
);

  localparam int CW   = $clog2(FW);
  localparam int NCAN = 6;
  localparam int IW   = $clog2(NCAN);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_CHECK} state_t;
  state_t state;

  logic [FW-1:0] src_q, core_q, lim_q, pmax_q;
  logic [FW-1:0] rem, quo;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  function automatic logic [HW-1:0] cand(input logic [IW-1:0] i);
    case (i)
      0:       cand = HW'(1);
      1:       cand = HW'(2);
      2:       cand = HW'(3);
      3:       cand = HW'(4);
      4:       cand = HW'(6);
      default: cand = HW'(8);
    endcase
  endfunction

  logic [HW-1:0] dcur;
  logic [FW:0]   trial;
  logic          fits;
  logic [FW-1:0] core_clamp, lim_init;
  logic          accept, sub2, perr;
  logic [FW-1:0] craise;

  assign dcur       = cand(idx);
  assign trial      = {rem, quo[FW-1]};
  assign fits       = trial >= {{(FW+1-HW){1'b0}}, dcur};
  assign core_clamp = (core_hz > src_hz) ? src_hz : core_hz;
  assign lim_init   = (core_clamp < src_hz && core_clamp < hbus_max_hz) ? core_clamp : hbus_max_hz;
  assign accept     = {1'b0, quo} <= ({1'b0, lim_q} + (FW+1)'(TOL));
  assign sub2       = quo > pmax_q;
  assign perr       = sub2 && ((quo >> 1) > pmax_q);
  assign craise     = (core_q < quo) ? quo : core_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      src_q      <= '0;
      core_q     <= '0;
      lim_q      <= '0;
      pmax_q     <= '0;
      rem        <= '0;
      quo        <= '0;
      cnt        <= '0;
      idx        <= '0;
      hdiv       <= '0;
      pdiv       <= '0;
      scale_mode <= 1'b0;
      core_adj   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          src_q  <= src_hz;
          core_q <= core_clamp;
          lim_q  <= lim_init;
          pmax_q <= pbus_max_hz;
          rem    <= '0;
          quo    <= src_hz;
          cnt    <= '0;
          idx    <= '0;
          err    <= 1'b0;
          state  <= S_DIV;
        end
        S_DIV: begin
          rem <= fits ? FW'(trial - {{(FW+1-HW){1'b0}}, dcur}) : trial[FW-1:0];
          quo <= {quo[FW-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(FW-1)) state <= S_CHECK;
        end
        S_CHECK: begin
          if (accept) begin
            state <= S_IDLE;
            done  <= 1'b1;
            if (perr) begin
              err <= 1'b1;
            end else begin
              hdiv       <= dcur;
              pdiv       <= sub2 ? {dcur, 1'b0} : {1'b0, dcur};
              scale_mode <= craise < src_q;
              core_adj   <= (craise < src_q) ? quo : craise;
            end
          end else if (idx == IW'(NCAN-1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            rem   <= '0;
            quo   <= src_q;
            cnt   <= '0;
            state <= S_DIV;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done || $past(start));  // R8
  AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ($stable(hdiv) && $stable(pdiv) && $stable(core_adj) && $stable(scale_mode)));  // R5
  AST_PDIV_MULT: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (pdiv == {1'b0, hdiv} || pdiv == {hdiv, 1'b0}));  // R6
  AST_HDIV_SET: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (hdiv inside {1, 2, 3, 4, 6, 8}));  // R4
  AST_SCALE_BELOW: assert property (@(posedge clk) disable iff (rst)
    (done && !err && scale_mode) |-> (core_adj < src_q));  // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && start) |=> $stable(src_q) && $stable(pmax_q));  // R9

endmodule

// File: tb/bus_div_select_test.sv
module bus_div_select_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_hz = '0, core_hz = '0, hbus_max_hz = '0, pbus_max_hz = '0;
  logic [3:0]  hdiv;
  logic [4:0]  pdiv;
  logic        scale_mode;
  logic [31:0] core_adj;
  logic        done, err;

  always #10 clk = ~clk;

  bus_div_select uut (
    .clk(clk), .rst(rst), .start(start), .src_hz(src_hz), .core_hz(core_hz),
    .hbus_max_hz(hbus_max_hz), .pbus_max_hz(pbus_max_hz), .hdiv(hdiv), .pdiv(pdiv),
    .scale_mode(scale_mode), .core_adj(core_adj), .done(done), .err(err)
  );

  typedef struct {
    logic        e;
    logic [3:0]  h;
    logic [4:0]  p;
    logic        s;
    logic [31:0] c;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t good;
  int checks = 0, fails = 0, pops = 0;
  bit fin = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [31:0] s, logic [31:0] c, logic [31:0] hm, logic [31:0] pm, string tag);
    exp_t r;
    int dl[6] = '{1, 2, 3, 4, 6, 8};
    logic [31:0] cc, lim, b, cr;
    bit found = 0;
    int dsel = 0;
    r = good;
    r.tag = tag;
    r.e = 1'b1;
    cc = (c > s) ? s : c;                         // R2
    lim = (cc < s && cc < hm) ? cc : hm;          // R3
    b = '0;
    foreach (dl[i]) if (!found) begin             // R4
      logic [31:0] qq;
      qq = s / dl[i];
      if (64'(qq) <= 64'(lim) + 1000) begin found = 1; dsel = dl[i]; b = qq; end
    end
    if (!found) return r;                         // R5
    if (b > pm && (b / 2) > pm) return r;         // R6
    r.e = 1'b0;
    r.h = 4'(dsel);
    r.p = (b > pm) ? 5'(2 * dsel) : 5'(dsel);
    cr = (cc < b) ? b : cc;                       // R7
    r.s = cr < s;
    r.c = r.s ? b : cr;
    good = r;
    return r;
  endfunction

  task automatic drive(logic [31:0] s, logic [31:0] c, logic [31:0] hm, logic [31:0] pm, string tag);
    q.push_back(model(s, c, hm, pm, tag));
    @(negedge clk);
    src_hz = s; core_hz = c; hbus_max_hz = hm; pbus_max_hz = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    do @(negedge clk); while (!done);
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk("R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        pops++;
        chk({e.tag, " err"}, err, e.e);
        chk({e.tag, " hdiv"}, hdiv, e.h);
        chk({e.tag, " pdiv"}, pdiv, e.p);
        chk({e.tag, " scale"}, scale_mode, e.s);
        chk({e.tag, " core_adj"}, core_adj, e.c);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!fin) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    good = '{1'b0, 4'd0, 5'd0, 1'b0, 32'd0, ""};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset hdiv", hdiv, 0);
    chk("R1 reset pdiv", pdiv, 0);
    chk("R1 reset flags", {scale_mode, done, err}, 0);
    chk("R1 reset core_adj", core_adj, 0);

    drive(400000000, 400000000, 133333333, 66666666, "R4 R6 nominal"); wait_done();
    drive(400000000, 100000000, 133333333, 66666666, "R3 R7 scaling"); wait_done();
    drive(300000000, 500000000, 150000000, 150000000, "R2 clamp"); wait_done();
    drive(300000, 300000, 99000, 1000000, "R4 tolerance edge"); wait_done();
    drive(300000, 300000, 98999, 1000000, "R4 tolerance miss"); wait_done();
    drive(1000000000, 1000000000, 100000, 100000, "R5 no divisor"); wait_done();
    drive(100000000, 100000000, 100000000, 10000000, "R6 sub over 2"); wait_done();
    drive(50000000, 50000000, 100000000, 100000000, "R4 unity"); wait_done();
    drive(600000000, 600000000, 100000000, 100000000, "R4 div6"); wait_done();
    drive(800000000, 800000000, 100000000, 60000000, "R6 div8 x2"); wait_done();
    drive(100000001, 100000001, 33333333, 40000000, "R4 floor"); wait_done();
    drive(300000, 99500, 1000000, 1000000, "R7 core raised"); wait_done();
    drive(60000000, 9000000, 133000000, 66000000, "R7 core lowered"); wait_done();

    // R9: strobe with other operands while busy
    drive(400000000, 400000000, 133333333, 66666666, "R9 first wins");
    repeat (5) @(negedge clk);
    src_hz = 32'd50000000; hbus_max_hz = 32'd200000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();

    // R10: start raised in the done cycle, after an error
    drive(1000000000, 1000000000, 100000, 100000, "R5 err before R10"); wait_done();
    q.push_back(model(200000000, 200000000, 100000000, 50000000, "R10 back to back"));
    src_hz = 200000000; core_hz = 200000000; hbus_max_hz = 100000000; pbus_max_hz = 50000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();

    for (int i = 0; i < 30; i++) begin
      logic [31:0] s, c, hm, pm;
      s  = 32'd1000 + ($urandom % 500000000);
      c  = $urandom % 600000000;
      hm = 32'd1000 + ($urandom % 200000000);
      pm = 32'd1000 + ($urandom % 100000000);
      drive(s, c, hm, pm, "R4 R6 R7 random");
      wait_done();
    end

    repeat (40) @(negedge clk);
    chk("R8 all results seen", q.size(), 0);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule